// File: doc/BRIEF.md
# I2C Register Bank Slave

This block lets a host controller on a two-wire I2C bus reach sixteen byte-wide registers inside a larger chip. The first four sub-addresses are read-only windows onto status bytes supplied by neighbouring core logic. The remaining twelve sub-addresses are write-only control bytes, and their values drive the block's control output bus.

The slave answers to the fixed 7-bit device address 1101110. The host sets a 4-bit register pointer with the first byte of a write transfer. Later bytes of the same transfer land in successive registers. To read, the host writes the pointer alone and ends that transfer with a stop. It then opens a read transfer, which streams bytes from the pointer onward.

SCL and SDA are sampled by the system clock through two-flop synchronizers. SDA is driven open-drain style: the block only ever pulls the line low, through a separate output enable. Clock stretching is not supported.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, every control byte on ctrl_o reads 0x00 and sda_oe_o is low.
- R2: The slave acknowledges address byte 0xDC (write) and 0xDD (read) by pulling SDA low during the ninth SCL pulse. Any other address byte gets no acknowledge, and the rest of that transfer has no effect.
- R3: In a write transfer, the first byte after the address loads the 4-bit pointer from its low nibble. Each later byte is stored at the pointer, after which the pointer increments. Every such byte is acknowledged.
- R4: Bytes written to sub-addresses 0 to 3 are acknowledged but change no control byte.
- R5: A read transfer sends bytes MSB first. Its first byte is the register at the pointer left by the previous write, and each further byte comes from the next sub-address.
- R6: A read of sub-address k in 0..3 returns status_i[8k+7:8k]. A read of any of sub-addresses 4 to 15 returns 0x00.
- R7: The pointer wraps from 15 to 0 on both writes and reads.
- R8: When the host answers a read byte with NACK (SDA high in the ninth pulse), the slave releases SDA and drives no further bits until the next start.
- R9: A stop condition anywhere returns the slave to idle, and a byte cut short by it is not stored. A start condition anywhere abandons the current transfer and begins a fresh address byte.
- R10: Control register n (4..15) appears on ctrl_o[8(n-4)+7 : 8(n-4)]. ctrl_o changes only as the result of an accepted write.
- R11: sda_oe_o changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_oe_o | output | 1 | High pulls SDA low |
| status_i | input | 32 | Four read-only status bytes, byte k for sub-address k |
| ctrl_o | output | 96 | Twelve control bytes, sub-addresses 4 to 15 |

## Verification
Assertions check several properties on every cycle. SDA is only ever driven during SCL-low changes. The slave is never driving while idle or in a receive phase. A stop always returns it to idle. Control bytes hold steady except on an accepted write, and never move on a write to a status sub-address. Only the bench scenarios can show the protocol-level results: address matching, pointer load and auto-increment with wrap, read data ordering from status and control space, the NACK release, and the handling of transfers cut off by a stop or a fresh start.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
    localparam int DW = 8;               // register width
    localparam int AW = 4;               // pointer width
    localparam int NREG = 1 << AW;       // register count
    localparam int CW = $clog2(DW);      // bit counter width

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_WRX, ST_WACK, ST_RTX, ST_RACK
    } fsm_st_e;

    typedef struct packed {
        fsm_st_e         st;
        logic [CW-1:0]   cnt;
        logic [DW-1:0]   sh;
        logic            got;
        logic [AW-1:0]   ptr;
        logic            sub_next;
        logic            rd;
        logic            oe;
        logic            wr;
        logic [AW-1:0]   widx;
        logic [DW-1:0]   wdat;
        logic            scl_p;
        logic            sda_p;
    } fsm_t;
endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;   // idle bus level
            else        chain_q <= {chain_q[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
    parameter int DW    = 8,
    parameter int AW    = 4,
    parameter int NREG  = 16,
    parameter int NSTAT = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_idx,
    input  logic [DW-1:0]                 wr_data,
    input  logic [AW-1:0]                 rd_idx,
    output logic [DW-1:0]                 rd_data,
    input  logic [NSTAT*DW-1:0]           status_i,
    output logic [(NREG-NSTAT)*DW-1:0]    ctrl_o
);
    localparam int NCTRL = NREG - NSTAT;

    logic [NCTRL-1:0][DW-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        for (int k = 0; k < NCTRL; k++) begin
            if (wr_en && int'(wr_idx) == k + NSTAT) ctrl_d[k] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NSTAT; k++) begin
            if (int'(rd_idx) == k) rd_data = status_i[k*DW +: DW];
        end
    end

    assign ctrl_o = ctrl_q;

    // R10
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));

    // R4
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) < NSTAT) |=> $stable(ctrl_q));
endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_idx,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [DW-1:0] wr_data,
    output logic          sda_oe
);
    fsm_t q, n;
    logic scl_rise, scl_fall, start_det, stop_det;

    always_comb begin
        n        = q;
        n.wr     = 1'b0;
        n.scl_p  = scl_s;
        n.sda_p  = sda_s;
        scl_rise  = scl_s & ~q.scl_p;
        scl_fall  = ~scl_s & q.scl_p;
        start_det = scl_s & q.scl_p & q.sda_p & ~sda_s;
        stop_det  = scl_s & q.scl_p & ~q.sda_p & sda_s;

        if (stop_det) begin
            n.st  = ST_IDLE;
            n.oe  = 1'b0;
            n.got = 1'b0;
        end else if (start_det) begin
            n.st  = ST_ADDR;
            n.cnt = '0;
            n.got = 1'b0;
            n.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_WRX: begin
                    if (scl_rise) begin
                        n.sh  = {q.sh[DW-2:0], sda_s};
                        n.cnt = q.cnt + 1'b1;
                        n.got = (q.cnt == CW'(DW-1));
                    end else if (scl_fall && q.got) begin
                        n.got = 1'b0;
                        n.cnt = '0;
                        if (q.st == ST_ADDR) begin
                            if (q.sh[DW-1:1] == DEV_ADDR) begin
                                n.oe = 1'b1;
                                n.rd = q.sh[0];
                                n.st = ST_AACK;
                            end else begin
                                n.st = ST_IDLE;
                            end
                        end else begin
                            if (q.sub_next) begin
                                n.ptr      = q.sh[AW-1:0];
                                n.sub_next = 1'b0;
                            end else begin
                                n.wr   = 1'b1;
                                n.widx = q.ptr;
                                n.wdat = q.sh;
                                n.ptr  = q.ptr + 1'b1;
                            end
                            n.oe = 1'b1;
                            n.st = ST_WACK;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        n.cnt = '0;
                        if (q.rd) begin
                            n.sh  = rd_data;
                            n.oe  = ~rd_data[DW-1];
                            n.ptr = q.ptr + 1'b1;
                            n.st  = ST_RTX;
                        end else begin
                            n.oe       = 1'b0;
                            n.sub_next = 1'b1;
                            n.st       = ST_WRX;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        n.oe  = 1'b0;
                        n.cnt = '0;
                        n.st  = ST_WRX;
                    end
                end
                ST_RTX: begin
                    if (scl_rise) begin
                        n.cnt = q.cnt + 1'b1;
                        n.got = (q.cnt == CW'(DW-1));
                    end else if (scl_fall) begin
                        if (q.got) begin
                            n.got = 1'b0;
                            n.oe  = 1'b0;
                            n.st  = ST_RACK;
                        end else begin
                            n.sh = {q.sh[DW-2:0], 1'b0};
                            n.oe = ~q.sh[DW-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_s) begin
                            n.st = ST_IDLE;
                            n.oe = 1'b0;
                        end else begin
                            n.got = 1'b1;
                        end
                    end else if (scl_fall && q.got) begin
                        n.got = 1'b0;
                        n.cnt = '0;
                        n.sh  = rd_data;
                        n.oe  = ~rd_data[DW-1];
                        n.ptr = q.ptr + 1'b1;
                        n.st  = ST_RTX;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.scl_p    <= 1'b1;
            q.sda_p    <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign rd_idx  = q.ptr;
    assign wr_en   = q.wr;
    assign wr_idx  = q.widx;
    assign wr_data = q.wdat;
    assign sda_oe  = q.oe;

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> $past(!scl_s));

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe);

    // R2
    drive_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> (q.st == ST_AACK || q.st == ST_WACK || q.st == ST_RTX));

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.st == ST_IDLE && !q.oe));

    // R3
    write_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |-> (q.st == ST_WACK && q.oe));
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101110,
    parameter int         NSTAT    = 4,
    parameter int         SYNC_STG = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    input  logic [NSTAT*DW-1:0]        status_i,
    output logic [(NREG-NSTAT)*DW-1:0] ctrl_o
);
    logic [1:0]    pins_s;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] rd_idx, wr_idx;
    logic [DW-1:0] wr_data;
    logic          wr_en;

    i2c_rb_sync #(.STAGES(SYNC_STG), .LINES(2)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (pins_s)
    );

    i2c_rb_fsm #(.DEV_ADDR(DEV_ADDR)) fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_s  (pins_s[1]),
        .sda_s  (pins_s[0]),
        .rd_data(rd_data),
        .rd_idx (rd_idx),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .sda_oe (sda_oe_o)
    );

    i2c_rb_regs #(.DW(DW), .AW(AW), .NREG(NREG), .NSTAT(NSTAT)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .status_i(status_i),
        .ctrl_o  (ctrl_o)
    );
endmodule

// File: tb/i2c_regbank_slave_tb.sv
module i2c_regbank_slave_tb_top;
    localparam int Q = 6;   // clocks per quarter SCL period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_scl = 1'b1;
    logic        host_low = 1'b0;
    logic        sda_oe;
    logic [31:0] status;
    logic [95:0] ctrl;
    wire         sda_line = ~(host_low | sda_oe);

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] model [16];

    always #2 clk = ~clk;   // 250 MHz

    i2c_regbank_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .status_i(status), .ctrl_o(ctrl)
    );

    // {pointer, data}: single-byte writes
    localparam logic [11:0] VEC [8] = '{
        {4'h4, 8'h5A}, {4'h9, 8'hC7}, {4'h1, 8'hEE}, {4'hB, 8'h01},
        {4'h0, 8'h99}, {4'h4, 8'hA5}, {4'h3, 8'h3C}, {4'hF, 8'h80}
    };

    task automatic tq(int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_ctrl(string req);
        bit bad = 0;
        checks++;
        for (int r = 4; r < 16; r++) begin
            if (ctrl[(r-4)*8 +: 8] !== model[r]) begin
                bad = 1;
                $display("FAIL %s reg%0d actual=%h expected=%h", req, r,
                         ctrl[(r-4)*8 +: 8], model[r]);
            end
        end
        if (bad) failures++;
    endtask

    task automatic i2c_start();
        host_low = 1'b0; tq(1); host_scl = 1'b1; tq(1);
        host_low = 1'b1; tq(1); host_scl = 1'b0; tq(1);
    endtask

    task automatic i2c_stop();
        host_low = 1'b1; tq(1); host_scl = 1'b1; tq(1);
        host_low = 1'b0; tq(1);
    endtask

    task automatic send_bits(logic [7:0] b, int nb);
        for (int i = 0; i < nb; i++) begin
            host_low = ~b[7-i]; tq(1); host_scl = 1'b1; tq(2);
            host_scl = 1'b0; tq(1);
        end
    endtask

    task automatic send_byte(logic [7:0] b, output logic ack);
        send_bits(b, 8);
        host_low = 1'b0; tq(1); host_scl = 1'b1; tq(1);
        ack = ~sda_line; tq(1); host_scl = 1'b0; tq(1);
    endtask

    task automatic recv_byte(logic host_ack, output logic [7:0] d);
        host_low = 1'b0;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            tq(1); host_scl = 1'b1; tq(1); d = {d[6:0], sda_line};
            tq(1); host_scl = 1'b0;
        end
        tq(1); host_low = host_ack; tq(1); host_scl = 1'b1; tq(2);
        host_scl = 1'b0; tq(1); host_low = 1'b0;
    endtask

    task automatic set_ptr(logic [3:0] p);
        logic a;
        i2c_start(); send_byte(8'hDC, a); send_byte({4'h0, p}, a); i2c_stop();
    endtask

    initial begin
        logic a, a2;
        logic [7:0] d;
        status = 32'hA1B2C3D4;
        for (int r = 0; r < 16; r++) model[r] = 8'h00;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk_ctrl("R1 ctrl after reset");
        chk8("R1 sda_oe after reset", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        tq(2);

        // R3 R4 R10: table of single writes
        for (int i = 0; i < 8; i++) begin
            i2c_start(); send_byte(8'hDC, a); send_byte({4'h0, VEC[i][11:8]}, a2);
            chk8("R2 write address ack", {7'd0, a}, 8'h01);
            send_byte(VEC[i][7:0], a);
            chk8("R3 data ack", {7'd0, a & a2}, 8'h01);
            i2c_stop();
            if (VEC[i][11:8] >= 4) model[VEC[i][11:8]] = VEC[i][7:0];
            chk_ctrl("R3 R4 R10 table write");
        end

        // R7 R4: burst write wraps F -> 0
        begin
            logic all_ack = 1'b1;
            i2c_start(); send_byte(8'hDC, a); all_ack &= a;
            send_byte(8'h0E, a); all_ack &= a;
            for (int k = 0; k < 7; k++) begin
                send_byte(8'h11 * (k + 1), a); all_ack &= a;
            end
            i2c_stop();
            model[14] = 8'h11; model[15] = 8'h22; model[4] = 8'h77;
            chk8("R3 burst acks", {7'd0, all_ack}, 8'h01);
            chk_ctrl("R7 burst wrap");
        end

        // R5 R6: read from status then into control space
        set_ptr(4'h2);
        i2c_start(); send_byte(8'hDD, a);
        chk8("R2 read address ack", {7'd0, a}, 8'h01);
        recv_byte(1'b1, d); chk8("R6 status byte 2", d, 8'hB2);
        recv_byte(1'b1, d); chk8("R5 next status byte 3", d, 8'hA1);
        recv_byte(1'b1, d); chk8("R6 control reads zero", d, 8'h00);
        recv_byte(1'b0, d); chk8("R6 control reads zero 2", d, 8'h00);
        // R8: after NACK the slave must not drive
        recv_byte(1'b0, d); chk8("R8 released after NACK", d, 8'hFF);
        i2c_stop();

        // R7: read wraps F -> 0
        set_ptr(4'hF);
        i2c_start(); send_byte(8'hDD, a);
        recv_byte(1'b1, d); chk8("R7 read reg F", d, 8'h00);
        recv_byte(1'b0, d); chk8("R7 read wrap to reg 0", d, 8'hD4);
        i2c_stop();

        // R6: status changes are visible
        status = 32'h0F1E2D3C;
        set_ptr(4'h0);
        i2c_start(); send_byte(8'hDD, a);
        recv_byte(1'b0, d); chk8("R6 new status byte 0", d, 8'h3C);
        i2c_stop();

        // R2: foreign address
        i2c_start(); send_byte(8'hA0, a);
        chk8("R2 foreign address no ack", {7'd0, a}, 8'h00);
        send_byte(8'h07, a);
        chk8("R2 no ack after foreign address", {7'd0, a}, 8'h00);
        send_byte(8'h33, a); i2c_stop();
        chk_ctrl("R2 foreign transfer ignored");

        // R9: stop in mid-byte
        i2c_start(); send_byte(8'hDC, a); send_byte(8'h05, a);
        send_bits(8'hC3, 4); i2c_stop();
        chk_ctrl("R9 partial byte dropped by stop");

        // R9: start in mid-byte restarts the address phase
        i2c_start(); send_byte(8'hDC, a); send_byte(8'h06, a);
        send_bits(8'h0F, 3);
        i2c_start(); send_byte(8'hDC, a);
        chk8("R9 address ack after restart", {7'd0, a}, 8'h01);
        send_byte(8'h06, a); send_byte(8'hAA, a); i2c_stop();
        model[6] = 8'hAA;
        chk_ctrl("R9 write after restart");
        chk8("R11 bus released at end", {7'd0, sda_oe}, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule